// File: doc/BRIEF.md
# Three-Phase Complementary Gate Driver with Dead Time

This block sits between a three-phase PWM modulator and the gate drivers of a bridge. Each of the three raw modulator signals is split into a complementary pair. One output switches the upper device of the leg and the other switches the lower device. Whenever a raw signal changes level, a programmable number of clock cycles passes before the newly selected device turns on. During that gap both devices of the leg are off, so the two switches of one leg never conduct at the same time.

The upper outputs are active high and the lower outputs are active low. A device is off whenever its output sits at its inactive level. An over-limit flag from an external comparator sets a latched fault. While the fault is set, all six outputs are forced to their inactive levels. The fault stays set until a clear request arrives while the over-limit flag is low. Each leg has its own dead-time counter, so a change on one leg does not disturb the other two.

Top module: `deadband_gate_stage`

## Requirements
- R1: While reset is asserted, every `gate_hi` bit is 0 and every `gate_lo_n` bit is 1, so all six devices are off.
- R2: For no leg is `gate_hi` at 1 while `gate_lo_n` is at 0 in the same cycle.
- R3: Suppose a leg's raw input is first sampled high at clock edge k, with `dead_cycles` = D at that edge, and it then stays high. The lower output goes inactive (`gate_lo_n` = 1) after edge k+1. The upper output goes active (`gate_hi` = 1) after edge k+D+1.
- R4: Suppose a leg's raw input is first sampled low at edge k, with `dead_cycles` = D, and it then stays low. The upper output goes inactive (`gate_hi` = 0) after edge k+1. The lower output goes active (`gate_lo_n` = 0) after edge k+D+1.
- R5: Suppose a raw pulse is sampled high on P consecutive edges and P <= D. Then the upper output of that leg never goes active. If P = D+1, the upper output is active for exactly one cycle, after edge k+D+1.
- R6: Polarity is fixed. An upper device is on when its `gate_hi` bit is 1. A lower device is on when its `gate_lo_n` bit is 0. Bit i of each output vector belongs to bit i of `pwm_in`.
- R7: When `over_limit` is sampled at 1 on an edge, all upper outputs are 0 and all lower outputs are 1 after that edge.
- R8: The fault stays latched after `over_limit` returns low. A `fault_clr` sampled while `over_limit` is 1 has no effect. A `fault_clr` sampled while `over_limit` is 0 releases the outputs after that edge, and they then follow the current state of each leg.
- R9: An edge on one leg's raw input leaves the outputs of the other legs unchanged.
- R10: With `dead_cycles` = 0, one device of a leg turns off and the other turns on after the same edge, edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 3 | Raw PWM level per leg, 1 selects the upper device |
| dead_cycles | input | 8 | Dead time in clock cycles, loaded on each raw edge |
| over_limit | input | 1 | Comparator flag; high sets the latched fault |
| fault_clr | input | 1 | Request to release the latched fault |
| gate_hi | output | 3 | Upper device gates, active high |
| gate_lo_n | output | 3 | Lower device gates, active low |

## Verification
A raw edge sampled at edge k turns the old device off after edge k+1 and turns the new one on after edge k+D+1. A fault sampled at an edge blanks the outputs after that same edge, and an accepted clear releases them after its own edge. The driver tasks change inputs on falling clock edges. They queue each expected leg state tagged with the edge count after which it must hold. The monitor compares those states 1 ns after the falling edge whose count matches. Because of this, every result is read exactly in the cycle the requirement names, not before and not after. Any expectation still queued or already overdue counts as a failure.

// File: rtl/deadband_gate_stage.sv
module deadband_gate_stage #(
  parameter int LEGS = 3,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LEGS-1:0] pwm_in,
  input  logic [DW-1:0]   dead_cycles,
  input  logic            over_limit,
  input  logic            fault_clr,
  output logic [LEGS-1:0] gate_hi,
  output logic [LEGS-1:0] gate_lo_n
);

  logic fault_q;
  logic fault_d;

  assign fault_d = over_limit | (fault_q & ~fault_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic          raw_q;
    logic [DW-1:0] cnt;
    logic          hi_r;
    logic          lo_r;
    logic          flip;
    logic          idle;

    assign flip = pwm_in[g] ^ raw_q;
    assign idle = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q <= 1'b0;
        cnt   <= '0;
        hi_r  <= 1'b0;
        lo_r  <= 1'b1;
      end else begin
        raw_q <= pwm_in[g];
        if (flip)       cnt <= dead_cycles;
        else if (!idle) cnt <= cnt - 1'b1;
        hi_r <= ~fault_d & raw_q & idle;
        lo_r <= ~(~fault_d & ~raw_q & idle);
      end
    end

    assign gate_hi[g]   = hi_r;
    assign gate_lo_n[g] = lo_r;

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_r && !lo_r));
  end

  // R7
  fault_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_limit |=> (gate_hi == '0 && (&gate_lo_n)));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !fault_clr) |=> fault_q);

  // R8
  clear_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && over_limit) |=> (fault_q && gate_hi == '0));

endmodule

// File: tb/deadband_gate_stage_tb.sv
module deadband_gate_stage_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pwm_in;
  logic [7:0] dead_cycles;
  logic       over_limit;
  logic       fault_clr;
  logic [2:0] gate_hi;
  logic [2:0] gate_lo_n;

  always #5 clk = ~clk;

  deadband_gate_stage dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dead_cycles(dead_cycles),
    .over_limit(over_limit), .fault_clr(fault_clr),
    .gate_hi(gate_hi), .gate_lo_n(gate_lo_n)
  );

  typedef struct {
    int    due;
    int    leg;
    logic  hi;
    logic  lon;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_leg(input int off, input int leg, input logic hi,
                            input logic lon, input string tag);
    exp_t it;
    int   pos;
    it.due = cyc + off; it.leg = leg; it.hi = hi; it.lon = lon; it.tag = tag;
    pos = sbq.size();
    for (int i = 0; i < sbq.size(); i++) begin
      if (sbq[i].due > it.due) begin pos = i; break; end
    end
    sbq.insert(pos, it);
  endtask

  task automatic expect_all_off(input int off, input string tag);
    for (int l = 0; l < 3; l++) expect_leg(off, l, 1'b0, 1'b1, tag);
  endtask

  task automatic direct(input string tag, input logic [5:0] act, input logic [5:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: {hi,lo_n} actual %b expected %b", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1) begin
      n_chk++;
      if ((gate_hi & ~gate_lo_n) != 3'b000) begin
        n_fail++;
        $display("FAIL R2: overlap hi=%b lo_n=%b expected no leg with both on",
                 gate_hi, gate_lo_n);
      end
    end
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t it;
      it = sbq.pop_front();
      n_chk++;
      if (it.due < cyc || gate_hi[it.leg] !== it.hi || gate_lo_n[it.leg] !== it.lon) begin
        n_fail++;
        $display("FAIL %s: leg %0d cycle %0d actual hi=%b lo_n=%b expected hi=%b lo_n=%b",
                 it.tag, it.leg, cyc, gate_hi[it.leg], gate_lo_n[it.leg], it.hi, it.lon);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm_in = 3'b000; dead_cycles = 8'd4;
    over_limit = 1'b0; fault_clr = 1'b0;
    step(2);
    #1 direct("R1", {gate_hi, gate_lo_n}, 6'b000_111);
    step(2);
    rst_n = 1'b1;
    step(3);
    #1 direct("R6", {gate_hi, gate_lo_n}, 6'b000_000);

    // R3: rising edge on leg 0 with D=4
    step(1);
    pwm_in[0] = 1'b1;
    expect_leg(1, 0, 1'b0, 1'b0, "R3");
    expect_leg(2, 0, 1'b0, 1'b1, "R3");
    expect_leg(5, 0, 1'b0, 1'b1, "R3");
    expect_leg(6, 0, 1'b1, 1'b1, "R3");
    step(10);

    // R4: falling edge on leg 0 with D=4
    pwm_in[0] = 1'b0;
    expect_leg(1, 0, 1'b1, 1'b1, "R4");
    expect_leg(2, 0, 1'b0, 1'b1, "R4");
    expect_leg(5, 0, 1'b0, 1'b1, "R4");
    expect_leg(6, 0, 1'b0, 1'b0, "R4");
    step(10);

    // R9: leg 2 moves, legs 0 and 1 stay put
    pwm_in[2] = 1'b1;
    for (int j = 1; j <= 8; j++) begin
      expect_leg(j, 0, 1'b0, 1'b0, "R9");
      expect_leg(j, 1, 1'b0, 1'b0, "R9");
    end
    expect_leg(6, 2, 1'b1, 1'b1, "R9");
    step(10);
    pwm_in[2] = 1'b0;
    step(10);

    // R5: pulse of P=D=5 edges gives no upper pulse
    dead_cycles = 8'd5;
    step(1);
    pwm_in[1] = 1'b1;
    for (int j = 1; j <= 11; j++) expect_leg(j, 1, 1'b0, (j == 1) ? 1'b0 : 1'b1, "R5");
    expect_leg(12, 1, 1'b0, 1'b0, "R5");
    step(5);
    pwm_in[1] = 1'b0;
    step(15);

    // R5: pulse of P=D+1=6 edges gives a single-cycle upper pulse
    pwm_in[1] = 1'b1;
    expect_leg(6, 1, 1'b0, 1'b1, "R5");
    expect_leg(7, 1, 1'b1, 1'b1, "R5");
    expect_leg(8, 1, 1'b0, 1'b1, "R5");
    step(6);
    pwm_in[1] = 1'b0;
    step(16);

    // R10: zero dead time
    dead_cycles = 8'd0;
    step(1);
    pwm_in[1] = 1'b1;
    expect_leg(1, 1, 1'b0, 1'b0, "R10");
    expect_leg(2, 1, 1'b1, 1'b1, "R10");
    step(5);
    pwm_in[1] = 1'b0;
    expect_leg(1, 1, 1'b1, 1'b1, "R10");
    expect_leg(2, 1, 1'b0, 1'b0, "R10");
    step(5);

    // R7 / R8: fault latch, blocked clear, accepted clear
    dead_cycles = 8'd4;
    pwm_in[0] = 1'b1;
    expect_leg(8, 0, 1'b1, 1'b1, "R7");
    step(10);
    over_limit = 1'b1;
    expect_all_off(1, "R7");
    step(2);
    over_limit = 1'b0;
    for (int j = 1; j <= 4; j++) expect_all_off(j, "R8");
    step(4);
    fault_clr = 1'b1;
    over_limit = 1'b1;
    expect_all_off(1, "R8");
    expect_all_off(2, "R8");
    step(2);
    over_limit = 1'b0;
    expect_leg(1, 0, 1'b1, 1'b1, "R8");
    expect_leg(1, 1, 1'b0, 1'b0, "R8");
    expect_leg(1, 2, 1'b0, 1'b0, "R8");
    step(1);
    fault_clr = 1'b0;
    step(5);

    if (sbq.size() > 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d items pending expected 0", sbq.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule